// File: doc/BRIEF.md
# Dual-Mode Burst Address Counter

This block produces the address sequence for a four-beat burst. A starting address is captured when either of two active-low address strobes is asserted: one driven by a processor, one by a cache controller. While the active-low advance input is held low, each rising clock edge then moves the burst to its next beat. Only the two least significant address bits change. The upper bits keep the value captured at load for the whole burst.

Two beat orders are supported. The order is chosen by a mode input that is sampled together with the starting address.

- **Interleaved order:** the low bits are the starting low bits XOR the beat index.
- **Linear order:** the low bits are the starting low bits plus the beat index, modulo four.

After the fourth beat, a further advance returns the counter to the loaded address. A flag marks the fourth beat so that a controller knows when the burst has been fully delivered.

Top module: `burst_addr_counter`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, the address output is all zeros and the last-beat flag is low.
- R2: When the processor strobe is low at a rising edge, the address output after that edge equals the start address input, and the last-beat flag is low.
- R3: When the controller strobe is low at a rising edge, the address output after that edge equals the start address input, and the last-beat flag is low. If both strobes are low, a single load takes place.
- R4: With the mode input high at load (interleaved), the low two bits on beat k (k = 0..3) equal the loaded low two bits XOR k.
- R5: With the mode input low at load (linear), the low two bits on beat k equal the loaded low two bits plus k, modulo 4.
- R6: The beat advances only at a rising edge where the advance input is low and no strobe is low. Otherwise the address output holds.
- R7: An advance taken on the fourth beat returns the address output to the loaded address, and the beat count restarts at 0.
- R8: Bits above bit 1 of the address output stay equal to the loaded value until the next load.
- R9: A strobe in the same cycle as an advance performs the load, and the advance is discarded.
- R10: The last-beat flag is high exactly on the fourth beat (beat index 3) of a burst.
- R11: The order is fixed at load. Changes on the mode input during a burst do not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| procStrobeN | input | 1 | Active-low load strobe from the processor side |
| ctrlStrobeN | input | 1 | Active-low load strobe from the cache-controller side |
| advanceN | input | 1 | Active-low burst advance |
| interleave | input | 1 | Order select sampled at load: 1 interleaved, 0 linear |
| startAddr | input | ADDR_W | Starting address captured at load |
| curAddr | output | ADDR_W | Address of the current beat |
| lastBeat | output | 1 | High on the fourth beat of the burst |

## Verification
The hardest case to reach from the ports is a load that collides with an advance on the fourth beat. The load must win, and the discarded advance must not also wrap the beat count. The stimulus first walks a burst to its last beat, then asserts a strobe and the advance together, and checks that the following beats restart from the new address at index 0. Two further cases need their own stimulus. A mode flip in the middle of a burst is driven between advances. Bursts are also run from every starting low-bit value in both orders, and each is advanced past the wrap so that the return to the loaded address is observed.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BEAT_W = 2;
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

  typedef struct packed {
    logic load;
    logic step;
  } burst_ctl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic [BEAT_W-1:0] beatIdx,
  output burst_ctl_t        ctl,
  output logic              lastBeat
);
  logic anyStrobe;

  always_comb begin
    anyStrobe = ~procStrobeN | ~ctrlStrobeN;
    ctl.load  = anyStrobe;
    // load wins over advance
    ctl.step  = ~anyStrobe & ~advanceN;
    lastBeat  = (beatIdx == LAST_BEAT);
  end
endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  burst_ctl_t        ctl,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic              modeReg;
  logic [BEAT_W-1:0] baseLow;
  logic [BEAT_W-1:0] seqLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      modeReg  <= 1'b0;
      beatIdx  <= '0;
    end else if (ctl.load) begin
      baseAddr <= startAddr;
      modeReg  <= interleave;
      beatIdx  <= '0;
    end else if (ctl.step) begin
      beatIdx  <= beatIdx + 1'b1;
    end
  end

  assign baseLow = baseAddr[BEAT_W-1:0];

  always_comb begin
    if (modeReg) seqLow = baseLow ^ beatIdx;
    else         seqLow = baseLow + beatIdx;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign curAddr = {baseAddr[ADDR_W-1:BEAT_W], seqLow};
    end else begin : g_low_only
      assign curAddr = seqLow[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lastBeat
);
  burst_ctl_t        ctl;
  logic [BEAT_W-1:0] beatIdx;

  burst_ctrl u_ctrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .beatIdx     (beatIdx),
    .ctl         (ctl),
    .lastBeat    (lastBeat)
  );

  burst_addr_path #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .interleave (interleave),
    .startAddr  (startAddr),
    .curAddr    (curAddr),
    .beatIdx    (beatIdx)
  );
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              interleave,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic              lastBeat
);
  logic              loadNow;
  logic [1:0]        stepCnt;
  logic [ADDR_W-1:0] loadedAddr;

  assign loadNow = ~procStrobeN | ~ctrlStrobeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt    <= '0;
      loadedAddr <= '0;
    end else if (loadNow) begin
      stepCnt    <= '0;
      loadedAddr <= startAddr;
    end else if (!advanceN) begin
      stepCnt    <= stepCnt + 2'd1;
    end
  end

  // R2/R3
  p_load_takes_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> (curAddr == $past(startAddr)) && !lastBeat);

  // R6
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadNow && advanceN) |=> $stable(curAddr) && $stable(lastBeat));

  // R8
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]));

  // R10
  p_last_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat == (stepCnt == 2'd3));

  // R7
  p_wrap_home_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !advanceN && !loadNow) |=> (curAddr == loadedAddr) && !lastBeat);

  // R9
  p_load_beats_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && !advanceN) |=> curAddr == $past(startAddr));
endmodule

bind burst_addr_counter burst_addr_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .advanceN    (advanceN),
  .interleave  (interleave),
  .startAddr   (startAddr),
  .curAddr     (curAddr),
  .lastBeat    (lastBeat)
);

// File: tb/burst_addr_counter_bench.sv
`timescale 1ns/1ps
module burst_addr_counter_bench;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              procStrobeN = 1'b1;
  logic              ctrlStrobeN = 1'b1;
  logic              advanceN = 1'b1;
  logic              interleave = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ADDR_W-1:0] curAddr;
  logic              lastBeat;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              last;
    string             req;
  } exp_t;

  exp_t expQ[$];

  // reference model state, built from the requirements
  logic [ADDR_W-1:0] mBase = '0;
  logic              mMode = 1'b0;
  int                mIdx = 0;

  always #10 clk = ~clk;

  burst_addr_counter #(.ADDR_W(ADDR_W)) u_burst_addr_counter (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .interleave(interleave), .startAddr(startAddr),
    .curAddr(curAddr), .lastBeat(lastBeat)
  );

  function automatic logic [ADDR_W-1:0] modelAddr();
    logic [1:0] lo;
    logic [1:0] k;
    k = mIdx[1:0];
    lo = mMode ? (mBase[1:0] ^ k) : (mBase[1:0] + k);
    return {mBase[ADDR_W-1:2], lo};
  endfunction

  function automatic void check(string req, logic [ADDR_W-1:0] a, logic l,
                                logic [ADDR_W-1:0] ea, logic el);
    testsRun++;
    if (a !== ea || l !== el) begin
      testsFailed++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b", req, a, l, ea, el);
    end
  endfunction

  // driver: apply one cycle of inputs, update the model, push the expectation
  task automatic drive(input logic pS, input logic cS, input logic adv,
                       input logic mode, input logic [ADDR_W-1:0] sa, input string req);
    exp_t e;
    procStrobeN = pS;
    ctrlStrobeN = cS;
    advanceN    = adv;
    interleave  = mode;
    startAddr   = sa;
    if (!pS || !cS) begin
      mBase = sa; mMode = mode; mIdx = 0;
    end else if (!adv) begin
      mIdx = (mIdx + 1) % 4;
    end
    e.addr = modelAddr();
    e.last = (mIdx == 3);
    e.req  = req;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.req, curAddr, lastBeat, e.addr, e.last);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: addr=%h last=%b expected completion", curAddr, lastBeat);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] sa;
    @(negedge clk);
    check("R1 in reset", curAddr, lastBeat, '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", curAddr, lastBeat, '0, 1'b0);

    // R4 / R5 / R7 / R2 / R3 / R10: every start, both orders, past the wrap
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        sa = {16'h1A5C + 16'(s * 7 + m), 2'(s)};
        if (s[0]) drive(1, 0, 1, m[0], sa, "R3 ctrl load");
        else      drive(0, 1, 1, m[0], sa, "R2 proc load");
        for (int b = 0; b < 5; b++)
          drive(1, 1, 0, ~m[0], '1, m[0] ? "R4 interleaved R7 R10 R11" : "R5 linear R7 R10 R11");
      end
    end

    // R6: hold without advance, with noise on mode and start address
    drive(0, 1, 1, 1, 18'h2F00E, "R2 load");
    drive(1, 1, 0, 1, '0, "R4 step");
    drive(1, 1, 1, 0, 18'h3FFFF, "R6 hold");
    drive(1, 1, 1, 1, 18'h12345, "R6 hold");
    drive(1, 1, 0, 0, '0, "R4 step R11");
    drive(1, 1, 0, 0, '0, "R10 last");
    drive(1, 1, 1, 0, '0, "R6 hold on last");

    // R9: load collides with advance on the fourth beat
    drive(0, 1, 0, 0, 18'h00541, "R9 load beats advance");
    drive(1, 1, 0, 1, '0, "R5 after R9");
    drive(1, 1, 0, 1, '0, "R5 after R9");
    drive(1, 1, 0, 1, '0, "R10 after R9");
    drive(1, 0, 0, 1, 18'h3AAA3, "R9 ctrl load on last");
    drive(1, 1, 0, 0, '0, "R4 after R9");

    // R3: both strobes together, R8 upper bits across a full burst
    drive(0, 0, 1, 0, 18'h3FFFF, "R3 both strobes");
    for (int b = 0; b < 4; b++) drive(1, 1, 0, 1, '0, "R8 upper fixed");

    drive(1, 1, 1, 0, '0, "R6 final hold");
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule